// File: doc/BRIEF.md
# Security-Banked Interrupt and Reset Control Register

This block is one 32-bit control register of a microcontroller interrupt controller. It sits on a simple single-cycle register port, and each access on that port carries a secure or non-secure attribute. The register keeps a 3-bit priority-grouping value for each security state. It also keeps three configuration bits that only secure software can change: a lock that stops non-secure software from requesting a system reset, a fault-target select and a priority-space select. A write has effect only when it carries the write key in its upper half. A keyed write can ask for a system reset, and the block reports that request as a one-cycle pulse.

The block also outputs a group-priority mask, which it builds from the non-secure grouping value. Downstream arbitration uses this mask. A parameter removes the security extension. When it is removed, every access is treated as non-secure, the three configuration bits become constants and the fault-target bit reads as one.

Top module: `sec_irq_ctrl_reg`

## Requirements
- R1: A write to the register changes no state and produces no reset pulse unless wdata[31:16] equals 0x05FA.
- R2: A read returns 0xFA05 in bits [31:16] and the grouping value of the access's security state in bits [10:8]. Bits 15, 12, 11, 7:4 and 2:0 read as zero.
- R3: The block keeps two separate 3-bit grouping copies. A keyed write loads wdata[10:8] into the copy that the access's secure attribute selects, and a read returns that same copy.
- R4: A keyed write with wdata[2]=1 makes sysreset_req_o high for exactly the following cycle when the access is secure or the lock bit is clear. A non-secure write while the lock is set produces no pulse.
- R5: Only a secure keyed write loads the lock (wdata[3]), the fault-target select (wdata[13]) and the priority-space select (wdata[14]). A non-secure write leaves all three unchanged.
- R6: A secure read shows the lock at bit 3, fault-target at bit 13 and priority-space at bit 14. A non-secure read shows only bit 13, and bits 3 and 14 read as zero.
- R7: grp_mask_o equals 0xFFFFFFFF shifted left by (non-secure grouping value + 1).
- R8: After reset, both grouping copies and all three configuration bits are zero, so grp_mask_o is 0xFFFFFFFE and sysreset_req_o is low.
- R9: Writing wdata bits 1 and 0 has no effect on any state or output.
- R10: An access to any address other than 0xD0C changes no state, gives no read response and gives no pulse.
- R11: rvalid_o is high, with the read data, in the cycle after a read of 0xD0C. At all other times rvalid_o is low and rdata_o is zero.
- R12: With SEC_EXT=0, every access uses the non-secure copy, the lock and priority-space bits read as zero, fault-target reads as one, and any keyed write with wdata[2]=1 produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access valid this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_secure_i | input | 1 | Secure attribute of the access |
| req_addr_i | input | 12 | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response, one cycle after the read |
| sysreset_req_o | output | 1 | One-cycle system-reset request |
| grp_mask_o | output | 32 | Group-priority mask from the non-secure grouping value |

## Verification
The hardest state to reach is a reset request that must be refused. For that, the lock has to be set by a secure write, and then a non-secure keyed write with bit 2 set has to arrive while the lock is still set. The stimulus first sets the lock from the secure side, then tries to clear it with a non-secure write, and then issues the non-secure reset request. It repeats the request after a secure write has cleared the lock, so that the pulse is seen both refused and granted. A second instance built without the security extension receives the same traffic.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int REG_W        = 32;
  localparam int GRP_W        = 3;
  localparam int GRP_LSB      = 8;
  localparam int LOCK_BIT     = 3;
  localparam int FTGT_BIT     = 13;
  localparam int PSPC_BIT     = 14;
  localparam int REQ_BIT      = 2;
  localparam logic [15:0] WR_KEY  = 16'h05FA;
  localparam logic [15:0] RD_SIG  = 16'hFA05;
  localparam logic [11:0] REG_OFS = 12'hD0C;

  typedef struct packed {
    logic pspc;
    logic ftgt;
    logic lock;
  } sec_cfg_t;
endpackage

// File: rtl/irc_decode.sv
module irc_decode
  import irc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = ADDR_W'(REG_OFS)
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       key_i,
  output logic              rd_hit_o,
  output logic              wr_keyed_o
);
  logic hit;
  assign hit        = valid_i && (addr_i == OFFSET);
  assign rd_hit_o   = hit && !write_i;
  assign wr_keyed_o = hit && write_i && (key_i == WR_KEY);
endmodule

// File: rtl/irc_group_bank.sv
module irc_group_bank #(
  parameter int W     = 3,
  parameter int BANKS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_val_i,
  input  logic         rd_sel_i,
  output logic [W-1:0] rd_val_o,
  output logic [W-1:0] ns_val_o
);
  logic [BANKS-1:0] sel_oh;
  logic [W-1:0]     bank [BANKS];

  assign sel_oh = BANKS'(1) << wr_sel_i;

  for (genvar g = 0; g < BANKS; g++) begin : gen_bank
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      q <= '0;
      else if (wr_en_i && sel_oh[g])    q <= wr_val_i;
    end
    assign bank[g] = q;
  end

  // index 0 = non-secure, 1 = secure
  assign rd_val_o = bank[rd_sel_i];
  assign ns_val_o = bank[0];
endmodule

// File: rtl/irc_sec_cfg.sv
module irc_sec_cfg
  import irc_pkg::*;
#(
  parameter bit SEC_EXT = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  logic     wr_sec_i,
  input  sec_cfg_t wr_val_i,
  output sec_cfg_t cfg_o
);
  if (SEC_EXT) begin : gen_state
    sec_cfg_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   q <= '0;
      else if (wr_en_i && wr_sec_i)  q <= wr_val_i;
    end
    assign cfg_o = q;
  end else begin : gen_const
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, wr_en_i, wr_sec_i, wr_val_i};
    assign cfg_o = '{pspc: 1'b0, ftgt: 1'b1, lock: 1'b0};
  end
endmodule

// File: rtl/irc_read_fmt.sv
module irc_read_fmt
  import irc_pkg::*;
(
  input  logic             sec_i,
  input  logic [GRP_W-1:0] grp_i,
  input  sec_cfg_t         cfg_i,
  output logic [REG_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    word_o[REG_W-1 -: 16]       = RD_SIG;
    word_o[GRP_LSB +: GRP_W]    = grp_i;
    word_o[FTGT_BIT]            = cfg_i.ftgt;
    if (sec_i) begin
      word_o[LOCK_BIT] = cfg_i.lock;
      word_o[PSPC_BIT] = cfg_i.pspc;
    end
  end
endmodule

// File: rtl/sec_irq_ctrl_reg.sv
module sec_irq_ctrl_reg
  import irc_pkg::*;
#(
  parameter bit SEC_EXT = 1'b1,
  parameter int ADDR_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_secure_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [REG_W-1:0]  req_wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              rvalid_o,
  output logic              sysreset_req_o,
  output logic [REG_W-1:0]  grp_mask_o
);
  localparam int SH_W = GRP_W + 1;

  logic             sec_eff, rd_hit, wr_keyed, rst_lock;
  logic [GRP_W-1:0] grp_rd, grp_ns;
  sec_cfg_t         cfg, cfg_wr;
  logic [REG_W-1:0] rd_word;
  logic [SH_W-1:0]  shamt;
  logic             unused_wbits;

  assign sec_eff  = req_secure_i & SEC_EXT;
  assign rst_lock = cfg.lock;
  assign cfg_wr   = '{pspc: req_wdata_i[PSPC_BIT], ftgt: req_wdata_i[FTGT_BIT],
                      lock: req_wdata_i[LOCK_BIT]};
  // bits 1:0 and reserved bits are ignored
  assign unused_wbits = ^{req_wdata_i[15], req_wdata_i[12:11],
                          req_wdata_i[7:4], req_wdata_i[1:0]};

  irc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i    (req_valid_i),
    .write_i    (req_write_i),
    .addr_i     (req_addr_i),
    .key_i      (req_wdata_i[REG_W-1 -: 16]),
    .rd_hit_o   (rd_hit),
    .wr_keyed_o (wr_keyed)
  );

  irc_group_bank #(.W(GRP_W), .BANKS(2)) u_grp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_keyed),
    .wr_sel_i (sec_eff),
    .wr_val_i (req_wdata_i[GRP_LSB +: GRP_W]),
    .rd_sel_i (sec_eff),
    .rd_val_o (grp_rd),
    .ns_val_o (grp_ns)
  );

  irc_sec_cfg #(.SEC_EXT(SEC_EXT)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_keyed),
    .wr_sec_i (sec_eff),
    .wr_val_i (cfg_wr),
    .cfg_o    (cfg)
  );

  irc_read_fmt u_fmt (
    .sec_i  (sec_eff),
    .grp_i  (grp_rd),
    .cfg_i  (cfg),
    .word_o (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o       <= 1'b0;
      rdata_o        <= '0;
      sysreset_req_o <= 1'b0;
    end else begin
      rvalid_o       <= rd_hit;
      rdata_o        <= rd_hit ? rd_word : '0;
      sysreset_req_o <= wr_keyed && req_wdata_i[REQ_BIT] && (sec_eff || !rst_lock);
    end
  end

  assign shamt      = {1'b0, grp_ns} + SH_W'(1);
  assign grp_mask_o = {REG_W{1'b1}} << shamt;
endmodule

// File: rtl/irc_ctrl_chk.sv
module irc_ctrl_chk
  import irc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [REG_W-1:0]  req_wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              rvalid_o,
  input logic              sysreset_req_o,
  input logic [REG_W-1:0]  grp_mask_o,
  input logic              sec_eff,
  input logic              rst_lock
);
  logic hit;
  assign hit = req_valid_i && (req_addr_i == ADDR_W'(REG_OFS));

  a_r1_bad_key_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && req_write_i && req_wdata_i[31:16] != WR_KEY) |=> (!sysreset_req_o && $stable(grp_mask_o)));

  a_r4_pulse_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysreset_req_o |-> $past(hit && req_write_i && req_wdata_i[31:16] == WR_KEY
                             && req_wdata_i[REQ_BIT] && (sec_eff || !rst_lock)));

  a_r11_rvalid_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(hit && !req_write_i));

  a_r2_signature: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o[31:16] == RD_SIG && rdata_o[2:0] == 3'b000));

  a_r6_ns_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !$past(sec_eff)) |-> (!rdata_o[PSPC_BIT] && !rdata_o[LOCK_BIT]));

  a_r7_mask_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_mask_o[31:8] == 24'hFFFFFF && !grp_mask_o[0]));
endmodule

bind sec_irq_ctrl_reg irc_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_write_i    (req_write_i),
  .req_addr_i     (req_addr_i),
  .req_wdata_i    (req_wdata_i),
  .rdata_o        (rdata_o),
  .rvalid_o       (rvalid_o),
  .sysreset_req_o (sysreset_req_o),
  .grp_mask_o     (grp_mask_o),
  .sec_eff        (sec_eff),
  .rst_lock       (rst_lock)
);

// File: tb/sec_irq_ctrl_reg_test.sv
module sec_irq_ctrl_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        v = 0, w = 0, s = 0;
  logic [11:0] addr = '0;
  logic [31:0] data = '0;

  logic [31:0] a_rdata, a_mask, b_rdata, b_mask;
  logic        a_rvalid, a_pulse, b_rvalid, b_pulse;

  sec_irq_ctrl_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_write_i(w), .req_secure_i(s),
    .req_addr_i(addr), .req_wdata_i(data), .rdata_o(a_rdata), .rvalid_o(a_rvalid),
    .sysreset_req_o(a_pulse), .grp_mask_o(a_mask));

  sec_irq_ctrl_reg #(.SEC_EXT(1'b0)) uut_nosec (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_write_i(w), .req_secure_i(s),
    .req_addr_i(addr), .req_wdata_i(data), .rdata_o(b_rdata), .rvalid_o(b_rvalid),
    .sysreset_req_o(b_pulse), .grp_mask_o(b_mask));

  int    total = 0, bad = 0;
  string cur_req = "R8";
  bit    finished = 0;

  // reference model
  logic [2:0]  m_grp [2];
  logic        m_lock, m_ft, m_ps, m_rvalid, m_pulse;
  logic [31:0] m_rdata;
  logic [2:0]  n_grp;
  logic        n_rvalid, n_pulse;
  logic [31:0] n_rdata;

  function automatic logic [31:0] fmt(logic [2:0] g, bit sec, bit lk, bit ft, bit ps);
    logic [31:0] r;
    r = 32'hFA05_0000 | ({29'd0, g} << 8) | ({31'd0, ft} << 13);
    if (sec) r = r | ({31'd0, lk} << 3) | ({31'd0, ps} << 14);
    return r;
  endfunction

  function automatic logic [31:0] mask_of(logic [2:0] g);
    return 32'hFFFF_FFFF << (int'(g) + 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_grp[0] = 0; m_grp[1] = 0; m_lock = 0; m_ft = 0; m_ps = 0;
      m_rvalid = 0; m_pulse = 0; m_rdata = 0;
      n_grp = 0; n_rvalid = 0; n_pulse = 0; n_rdata = 0;
    end else begin
      bit hit, keyed;
      hit   = v && addr == 12'hD0C;
      keyed = hit && w && data[31:16] == 16'h05FA;
      m_rvalid = hit && !w;
      m_rdata  = m_rvalid ? fmt(m_grp[s], s, m_lock, m_ft, m_ps) : 32'h0;
      m_pulse  = keyed && data[2] && (s || !m_lock);
      n_rvalid = hit && !w;
      n_rdata  = n_rvalid ? fmt(n_grp, 1'b0, 1'b0, 1'b1, 1'b0) : 32'h0;
      n_pulse  = keyed && data[2];
      if (keyed) begin
        m_grp[s] = data[10:8];
        if (s) begin m_lock = data[3]; m_ft = data[13]; m_ps = data[14]; end
        n_grp = data[10:8];
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check(cur_req, "rvalid", {31'd0, a_rvalid}, {31'd0, m_rvalid});
    check(cur_req, "rdata",  a_rdata, m_rdata);
    check(cur_req, "pulse",  {31'd0, a_pulse}, {31'd0, m_pulse});
    check(cur_req, "mask",   a_mask, mask_of(m_grp[0]));
    check("R12", "nosec rvalid", {31'd0, b_rvalid}, {31'd0, n_rvalid});
    check("R12", "nosec rdata",  b_rdata, n_rdata);
    check("R12", "nosec pulse",  {31'd0, b_pulse}, {31'd0, n_pulse});
    check("R12", "nosec mask",   b_mask, mask_of(n_grp));
  end

  task automatic acc(bit wr, bit sec, logic [11:0] a, logic [31:0] d);
    @(negedge clk); #1;
    v = 1; w = wr; s = sec; addr = a; data = d;
  endtask

  task automatic idle(int n);
    @(negedge clk); #1;
    v = 0; w = 0; s = 0; addr = '0; data = '0;
    repeat (n - 1) @(negedge clk);
  endtask

  function automatic logic [31:0] kw(logic [15:0] lo);
    return {16'h05FA, lo};
  endfunction

  localparam logic [11:0] A = 12'hD0C;

  initial begin
    repeat (3) @(negedge clk);
    #5 rst_n = 1;
    @(negedge clk); #2;
    cur_req = "R8";
    check("R8", "reset mask", a_mask, 32'hFFFF_FFFE);
    check("R8", "reset pulse", {31'd0, a_pulse}, 32'd0);
    acc(0, 1, A, 0); acc(0, 0, A, 0); idle(2);

    cur_req = "R2";
    acc(0, 1, A, 32'hFFFF_FFFF); idle(2);

    cur_req = "R3";
    acc(1, 1, A, kw(16'h0500)); acc(1, 0, A, kw(16'h0200));
    acc(0, 1, A, 0); acc(0, 0, A, 0); idle(2);

    cur_req = "R7";
    acc(1, 0, A, kw(16'h0700)); idle(2);
    acc(1, 0, A, kw(16'h0000)); idle(2);
    acc(1, 0, A, kw(16'h0300)); idle(2);

    cur_req = "R1";
    acc(1, 1, A, 32'h05FB_6604); acc(1, 0, A, 32'h0000_0104);
    acc(1, 1, A, 32'hFA05_6708); acc(0, 1, A, 0); idle(2);

    cur_req = "R5";
    acc(1, 1, A, kw(16'h6108)); acc(1, 0, A, kw(16'h0400));
    acc(0, 1, A, 0); idle(2);

    cur_req = "R6";
    acc(0, 0, A, 0); idle(2);

    cur_req = "R4";
    acc(1, 0, A, kw(16'h0404)); idle(2);
    acc(1, 1, A, kw(16'h610C)); idle(2);
    acc(1, 1, A, kw(16'h0100)); acc(1, 0, A, kw(16'h0404));
    acc(1, 0, A, kw(16'h0404)); idle(2);

    cur_req = "R9";
    acc(1, 1, A, kw(16'h0103)); acc(1, 0, A, kw(16'h0403));
    acc(0, 1, A, 0); idle(2);

    cur_req = "R10";
    acc(1, 1, 12'hD08, kw(16'h6F0C)); acc(0, 1, 12'hD08, 0);
    acc(1, 0, 12'hD10, kw(16'h0704)); idle(2);
    acc(0, 1, A, 0); idle(2);

    cur_req = "R11";
    acc(0, 0, A, 0); acc(0, 1, A, 0); idle(3);

    idle(2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule